// File: doc/BRIEF.md
# Framed Serial Transmitter with Idle and Break Frames

This block drives an asynchronous serial TX line. Bytes arrive through a single-entry holding register with a valid/ready handshake. Each byte goes out as one low start bit, eight data bits with the least significant bit first, and then a high stop period of selectable length. Timing comes from `half_tick_i`, a one-cycle pulse at twice the bit rate. Every line period is counted in half-bit units, so stop lengths of half a bit and one and a half bits come out exactly.

When `tx_en_i` goes high, the block first sends one idle frame before any data. An idle frame holds the line high for as long as a normal frame. A one-cycle pulse on `brk_set_i` requests a break frame. A break frame holds the line low for the start and data bit times, then adds the selected stop period. The request stays visible on `brk_pend_o` until that break frame has finished. No frame starts while `tx_en_i` is low, and a frame already under way always completes.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_o` is 1, `busy_o` is 0, `ready_o` is 1 and `brk_pend_o` is 0.
- R2: Once `tx_en_i` has risen, the first frame is an idle frame. It is 18 half-bit periods high followed by the stop period, and it is sent before any pending break or data.
- R3: A data frame is 2 halves low (start), then each data bit for 2 halves, bit 0 first, then the stop period high.
- R4: `stop_sel_i` is sampled at frame start: 2'b00 gives 2 halves, 2'b01 gives 1 half, 2'b10 gives 4 halves and 2'b11 gives 3 halves of stop.
- R5: A break frame is 18 halves low followed by the stop period. `brk_pend_o` rises after a `brk_set_i` pulse and falls in the same cycle that `busy_o` falls at the end of the break frame.
- R6: While `tx_en_i` is low, no frame starts: `busy_o` stays 0 and `tx_o` stays 1 even with a buffered byte.
- R7: The holding register takes one byte. `ready_o` is 0 while it is full and not being emptied into the shifter.
- R8: `tx_o` is 1 whenever `busy_o` is 0. `busy_o` falls only on a half tick, at the end of the last stop half.
- R9: During a frame, `tx_o` changes only after a cycle in which `half_tick_i` was 1.
- R10: When several frames are waiting, the order is idle frame, then break frame, then data frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle pulse every half bit period |
| tx_en_i | input | 1 | Transmit enable |
| stop_sel_i | input | 2 | Stop length code |
| brk_set_i | input | 1 | Pulse requesting a break frame |
| brk_pend_o | output | 1 | Break requested and not yet completed |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | `data_i` offered |
| ready_o | output | 1 | Holding register can accept a byte |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | A frame is on the line |

## Verification
The assertions take for granted that `half_tick_i` is a single-cycle pulse with idle cycles between pulses. They also assume `tx_en_i` and `brk_set_i` come from synchronous logic, so a frame start always follows a cycle with enable high. The stimulus raises the half tick on every fourth clock and changes inputs only on falling clock edges. It alters `stop_sel_i` only while the line is idle and the holding register is empty, so every captured frame can be compared with one stop length.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;
  typedef enum logic [1:0] {FK_IDLE, FK_BRK, FK_DATA} frame_kind_e;
  typedef enum logic [1:0] {SH_IDLE, SH_BODY, SH_STOP} sh_state_e;

  // stop length in half-bit units
  function automatic logic [2:0] stop_halves(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd2;
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      default: return 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/uart_frame_tx_hold.sv
module uart_frame_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic          pop_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  logic          full_q;
  logic [DW-1:0] data_q;

  // a pop frees the slot in the same cycle
  assign ready_o = !full_q || pop_i;
  assign full_o  = full_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (valid_i && ready_o) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_tx_sched.sv
module uart_frame_tx_sched
  import uart_frame_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  input  logic        brk_set_i,
  input  logic        can_start_i,
  input  logic        buf_full_i,
  input  logic        done_i,
  input  frame_kind_e done_kind_i,
  output logic        start_o,
  output frame_kind_e kind_o,
  output logic        pop_o,
  output logic        brk_pend_o
);
  logic en_q, idle_pend_q, brk_pend_q, go;

  // enable must be seen for a cycle so the idle frame wins over a full buffer
  assign go         = tx_en_i && en_q;
  assign kind_o     = idle_pend_q ? FK_IDLE : (brk_pend_q ? FK_BRK : FK_DATA);
  assign start_o    = go && can_start_i && (idle_pend_q || brk_pend_q || buf_full_i);
  assign pop_o      = start_o && (kind_o == FK_DATA);
  assign brk_pend_o = brk_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      idle_pend_q <= 1'b0;
      brk_pend_q  <= 1'b0;
    end else begin
      en_q <= tx_en_i;
      if (!tx_en_i)                           idle_pend_q <= 1'b0;
      else if (!en_q)                         idle_pend_q <= 1'b1;
      else if (start_o && kind_o == FK_IDLE)  idle_pend_q <= 1'b0;
      if (brk_set_i)                          brk_pend_q <= 1'b1;
      else if (done_i && done_kind_i == FK_BRK) brk_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_tx_shift.sv
module uart_frame_tx_shift
  import uart_frame_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_tick_i,
  input  logic          start_i,
  input  frame_kind_e   kind_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    stop_sel_i,
  output logic          busy_o,
  output logic          tx_o,
  output logic          done_o,
  output frame_kind_e   kind_o
);
  localparam int BODY_BITS = DW + 1;
  localparam int CW = $clog2(BODY_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(BODY_BITS - 1);

  sh_state_e            st_q;
  logic [BODY_BITS-1:0] shreg_q;
  logic [CW-1:0]        bit_q;
  logic                 phase_q;
  logic [2:0]           stop_left_q;
  frame_kind_e          kind_q;

  assign busy_o = (st_q != SH_IDLE);
  assign tx_o   = (st_q == SH_BODY) ? shreg_q[0] : 1'b1;
  assign done_o = (st_q == SH_STOP) && half_tick_i && (stop_left_q == 3'd0);
  assign kind_o = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SH_IDLE;
      shreg_q     <= '1;
      bit_q       <= '0;
      phase_q     <= 1'b0;
      stop_left_q <= '0;
      kind_q      <= FK_IDLE;
    end else begin
      case (st_q)
        SH_IDLE: if (start_i) begin
          st_q        <= SH_BODY;
          kind_q      <= kind_i;
          bit_q       <= '0;
          phase_q     <= 1'b0;
          stop_left_q <= stop_halves(stop_sel_i) - 3'd1;
          case (kind_i)
            FK_DATA: shreg_q <= {data_i, 1'b0};
            FK_IDLE: shreg_q <= '1;
            default: shreg_q <= '0;
          endcase
        end
        SH_BODY: if (half_tick_i) begin
          phase_q <= !phase_q;
          if (phase_q) begin
            shreg_q <= {1'b1, shreg_q[BODY_BITS-1:1]};
            if (bit_q == LAST_BIT) st_q <= SH_STOP;
            else                   bit_q <= bit_q + 1'b1;
          end
        end
        SH_STOP: if (half_tick_i) begin
          if (stop_left_q == 3'd0) st_q <= SH_IDLE;
          else                     stop_left_q <= stop_left_q - 3'd1;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_tick_i,
  input  logic          tx_en_i,
  input  logic [1:0]    stop_sel_i,
  input  logic          brk_set_i,
  output logic          brk_pend_o,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          tx_o,
  output logic          busy_o
);
  logic          pop, full, start, done;
  logic [DW-1:0] buf_data;
  frame_kind_e   kind, done_kind;

  uart_frame_tx_hold #(.DW(DW)) u_hold (
    .clk_i, .rst_ni, .data_i, .valid_i, .ready_o,
    .pop_i(pop), .full_o(full), .data_o(buf_data)
  );

  uart_frame_tx_sched u_sched (
    .clk_i, .rst_ni, .tx_en_i, .brk_set_i,
    .can_start_i(!busy_o), .buf_full_i(full),
    .done_i(done), .done_kind_i(done_kind),
    .start_o(start), .kind_o(kind), .pop_o(pop), .brk_pend_o
  );

  uart_frame_tx_shift #(.DW(DW)) u_shift (
    .clk_i, .rst_ni, .half_tick_i,
    .start_i(start), .kind_i(kind), .data_i(buf_data), .stop_sel_i,
    .busy_o, .tx_o, .done_o(done), .kind_o(done_kind)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic half_tick_i,
  input logic tx_en_i,
  input logic brk_pend_o,
  input logic tx_o,
  input logic busy_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  a_r8_end_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $fell(busy_o) |-> $past(half_tick_i));

  a_r9_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (busy_o && $past(busy_o) && !$past(half_tick_i)) |-> $stable(tx_o));

  a_r6_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $rose(busy_o) |-> $past(tx_en_i));

  a_r5_brk_clear_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $fell(brk_pend_o) |-> $fell(busy_o));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .half_tick_i(half_tick_i), .tx_en_i(tx_en_i),
  .brk_pend_o(brk_pend_o), .tx_o(tx_o), .busy_o(busy_o)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] stop_sel = 2'b00;
  logic       brk_set = 1'b0;
  logic       brk_pend;
  logic [7:0] data = 8'h00;
  logic       valid = 1'b0;
  logic       ready, tx, busy;

  always #10 clk = ~clk;

  uart_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .half_tick_i(tick), .tx_en_i(tx_en),
    .stop_sel_i(stop_sel), .brk_set_i(brk_set), .brk_pend_o(brk_pend),
    .data_i(data), .valid_i(valid), .ready_o(ready), .tx_o(tx), .busy_o(busy)
  );

  int total = 0, bad = 0, frames = 0, nf = 0;
  int tdiv = 0, cap_n = 0, fin_n = 0;
  logic prev_busy = 1'b0;
  logic cap [0:63];
  logic fin [0:63];

  // tick generator and line monitor in one process; one sample per half bit
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 3);
    if (busy && !prev_busy) cap_n = 0;
    if (busy && tick) begin
      if (cap_n < 64) cap[cap_n] = tx;
      cap_n++;
    end
    if (!busy && prev_busy) begin
      for (int i = 0; i < 64; i++) fin[i] = cap[i];
      fin_n = cap_n;
      frames++;
    end
    prev_busy = busy;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int halves(input logic [1:0] sel);
    case (sel)
      2'b00: return 2;
      2'b01: return 1;
      2'b10: return 4;
      default: return 3;
    endcase
  endfunction

  // kind: 0 idle, 1 break, 2 data
  task automatic expect_frame(input string req, input int kind, input logic [7:0] d,
                              input logic [1:0] sel);
    logic exp [0:63];
    int n, mism;
    while (frames <= nf) @(negedge clk);
    nf++;
    n = 18 + halves(sel);
    for (int b = 0; b < 9; b++) begin
      logic v;
      if (kind == 0)      v = 1'b1;
      else if (kind == 1) v = 1'b0;
      else                v = (b == 0) ? 1'b0 : d[b-1];
      exp[2*b] = v;
      exp[2*b+1] = v;
    end
    for (int i = 18; i < n; i++) exp[i] = 1'b1;
    chk({req, " frame length"}, fin_n, n);
    mism = 0;
    for (int i = 0; i < n && i < fin_n; i++) if (fin[i] !== exp[i]) mism++;
    chk({req, " half-bit mismatches"}, mism, 0);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    data = d;
    valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] vals [0:5];
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5;
    vals[3] = 8'h3C; vals[4] = 8'h01; vals[5] = 8'h80;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx", tx, 1); chk("R1 busy", busy, 0);
    chk("R1 ready", ready, 1); chk("R1 brk_pend", brk_pend, 0);

    // disabled: byte waits
    push(8'h5A);
    repeat (60) @(negedge clk);
    chk("R6 busy while disabled", busy, 0);
    chk("R6 tx while disabled", tx, 1);
    chk("R7 ready when full", ready, 0);

    tx_en = 1'b1;
    expect_frame("R2 idle on enable", 0, 8'h00, 2'b00);
    expect_frame("R3 data after idle", 2, 8'h5A, 2'b00);
    chk("R7 ready after drain", ready, 1);

    // stop length sweep over data patterns
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 6; k++) begin
        stop_sel = s[1:0];
        push(vals[k]);
        expect_frame("R4 stop/data sweep", 2, vals[k], s[1:0]);
      end
    end

    // back-to-back: second byte buffered during the first frame
    stop_sel = 2'b01;
    push(8'hE7);
    push(8'h18);
    @(negedge clk);
    chk("R7 ready low while holding", ready, 0);
    expect_frame("R3 first of pair", 2, 8'hE7, 2'b01);
    expect_frame("R3 second of pair", 2, 8'h18, 2'b01);

    // break and data requested together: break first
    stop_sel = 2'b11;
    @(negedge clk);
    brk_set = 1'b1; data = 8'hC3; valid = 1'b1;
    @(negedge clk);
    brk_set = 1'b0; valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 brk_pend during break", brk_pend, 1);
    expect_frame("R5 break frame", 1, 8'h00, 2'b11);
    chk("R5 brk_pend cleared", brk_pend, 0);
    expect_frame("R10 data after break", 2, 8'hC3, 2'b11);

    // all three pending at enable: idle, break, data
    stop_sel = 2'b10;
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
    push(8'h96);
    repeat (20) @(negedge clk);
    chk("R6 no break while disabled", busy, 0);
    chk("R5 brk_pend held while disabled", brk_pend, 1);
    tx_en = 1'b1;
    expect_frame("R10 idle first", 0, 8'h00, 2'b10);
    expect_frame("R10 break second", 1, 8'h00, 2'b10);
    expect_frame("R10 data third", 2, 8'h96, 2'b10);
    @(negedge clk);
    chk("R8 line high after frames", tx, 1);
    chk("R8 not busy after frames", busy, 0);

    summary();
    $finish;
  end
endmodule